// File: doc/BRIEF.md
# Bus-Loadable Masked Output Register Bank

This block holds sixteen output flip-flops, organised as two groups of eight. In normal operation each flip-flop follows its own internal logic. That logic supplies a next-state value, a clock enable, a synchronous preset and a synchronous clear for every bit.

A microcontroller reaches the bank through a small synchronous bus: an address, write data, a write strobe and read data. It can overwrite the bits of a group and read them back. Each group has its own mask register, and a mask bit of 1 shields that flip-flop from bus writes. A configuration input picks how writes land. In level mode, data is loaded on every clock where the strobe is high. In edge mode, data is loaded once, when the strobe falls.

Each bit also has an output enable for its pin. The enable is the OR of a per-bit direction-register bit and a per-bit enable term. When no enable term is configured for a bit, a per-bit "declared as output" flag takes the place of the term, so a declared output is driven straight out of reset.

Top module: `outreg_bank`

## Requirements
- R1: After reset, every flip-flop, mask register and direction register holds 0, and all eight addresses read back 0.
- R2: In level mode (edge_mode=0), at every rising clock edge where bus_wr=1 and bus_addr selects a flip-flop group (0 = bits 7:0, 1 = bits 15:8), the unmasked bits of that group take bus_wdata. The other group is not affected by the write.
- R3: In edge mode (edge_mode=1), nothing is loaded while bus_wr stays high. At the first clock edge where bus_wr is sampled low after being high, the write takes effect, using the address and data sampled at the last edge where bus_wr was high.
- R4: A mask bit of 1 (mask0 at address 2 covers bits 7:0, mask1 at address 3 covers bits 15:8) blocks bus writes to its flip-flop, which keeps following its internal logic. For example, mask 0x0F keeps bits 3:0 of the group and lets bits 7:4 load.
- R5: For an unmasked bit, a bus write overrides the internal preset, clear and clock enable in that cycle.
- R6: Without a bus write to a bit, the bit updates synchronously by priority. int_set forces 1. Otherwise int_clr forces 0. Otherwise int_ce loads int_d. Otherwise the bit holds.
- R7: bus_rdata is a combinational readback of the addressed register. Addresses 0 and 1 are the flip-flop groups, 2 and 3 are the masks, and 4 and 5 are the direction registers (even address = bits 7:0). Addresses 6 and 7 read 0.
- R8: oe[i] = dir[i] OR (term_cfg[i] ? oe_term[i] : out_decl[i]), as a combinational function.
- R9: Mask and direction registers are written by the same load event as the flip-flops, in either mode, and are not masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_mode | input | 1 | 1 = load on strobe fall, 0 = load while strobe high |
| bus_wr | input | 1 | Write strobe, active high, sampled on clk |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Readback of addressed register |
| int_d | input | 16 | Internal next-state data per bit |
| int_set | input | 16 | Internal synchronous preset per bit |
| int_clr | input | 16 | Internal synchronous clear per bit |
| int_ce | input | 16 | Internal clock enable per bit |
| oe_term | input | 16 | Per-bit output-enable term |
| term_cfg | input | 16 | 1 = enable term is configured for the bit |
| out_decl | input | 16 | 1 = bit is declared an output |
| q | output | 16 | Flip-flop outputs |
| oe | output | 16 | Pin output enables |

## Verification
Level-mode writes and internal updates show up on q one clock edge after the stimulus is sampled. An edge-mode write shows up one edge after bus_wr is first sampled low, so it reaches q two edges after its data was last presented. Readback and output enables are combinational and are compared in the same cycle as their inputs. The bench drives inputs one time unit after a rising edge. It checks combinational outputs before the next edge and checks q one time unit after that edge, against a cycle model that applies the load rules above.

// File: rtl/outreg_pkg.sv
package outreg_pkg;

  // Register class selected by a bus address.
  typedef enum logic [1:0] {
    SEL_FLOP = 2'd0,
    SEL_MASK = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  // Address layout: flop groups first, then masks, then direction registers.
  function automatic sel_e addr_sel(input int unsigned a, input int unsigned ngrp);
    if (a < ngrp)          return SEL_FLOP;
    else if (a < 2 * ngrp) return SEL_MASK;
    else if (a < 3 * ngrp) return SEL_DIR;
    return SEL_NONE;
  endfunction

  function automatic int unsigned addr_grp(input int unsigned a, input int unsigned ngrp);
    return a % ngrp;
  endfunction

  function automatic int unsigned flop_addr(input int unsigned g);
    return g;
  endfunction

  function automatic int unsigned mask_addr(input int unsigned g, input int unsigned ngrp);
    return ngrp + g;
  endfunction

  function automatic int unsigned dir_addr(input int unsigned g, input int unsigned ngrp);
    return 2 * ngrp + g;
  endfunction

  // Next state of one flop: a bus load wins, then preset, clear, enable, hold.
  function automatic logic bit_next(input logic bus_ld, input logic bus_val,
                                    input logic set, input logic clr,
                                    input logic ce, input logic d,
                                    input logic cur);
    if (bus_ld)   return bus_val;
    else if (set) return 1'b1;
    else if (clr) return 1'b0;
    else if (ce)  return d;
    return cur;
  endfunction

  // Pin enable: direction bit, or the term if configured, else the output flag.
  function automatic logic oe_bit(input logic dir, input logic term_cfg,
                                  input logic term, input logic decl);
    return dir | (term_cfg ? term : decl);
  endfunction

endpackage

// File: rtl/outreg_bus_ctrl.sv
module outreg_bus_ctrl #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_mode,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              ld_evt,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data
);

  logic              wr_q;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              strobe_fall;

  // Keep the last strobe level and the address/data seen while it was high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      wr_q <= bus_wr;
      if (bus_wr) begin
        hold_addr <= bus_addr;
        hold_data <= bus_wdata;
      end
    end
  end

  assign strobe_fall = wr_q & ~bus_wr;

  always_comb begin
    if (edge_mode) begin
      ld_evt  = strobe_fall;
      ld_addr = hold_addr;
      ld_data = hold_data;
    end else begin
      ld_evt  = bus_wr;
      ld_addr = bus_addr;
      ld_data = bus_wdata;
    end
  end

endmodule

// File: rtl/outreg_group.sv
module outreg_group
  import outreg_pkg::*;
#(
  parameter int GRP_W   = 8,
  parameter int ADDR_W  = 3,
  parameter int NUM_GRP = 2,
  parameter int GRP_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_evt,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [GRP_W-1:0]  ld_data,
  input  logic [GRP_W-1:0]  int_d,
  input  logic [GRP_W-1:0]  int_set,
  input  logic [GRP_W-1:0]  int_clr,
  input  logic [GRP_W-1:0]  int_ce,
  input  logic [GRP_W-1:0]  oe_term,
  input  logic [GRP_W-1:0]  term_cfg,
  input  logic [GRP_W-1:0]  out_decl,
  output logic [GRP_W-1:0]  q,
  output logic [GRP_W-1:0]  mask,
  output logic [GRP_W-1:0]  dir,
  output logic [GRP_W-1:0]  oe,
  output logic [GRP_W-1:0]  ld_bits
);

  localparam int unsigned FLOP_A = flop_addr(GRP_IDX);
  localparam int unsigned MASK_A = mask_addr(GRP_IDX, NUM_GRP);
  localparam int unsigned DIR_A  = dir_addr(GRP_IDX, NUM_GRP);

  logic [31:0]      addr_ext;
  logic             hit_flop;
  logic             hit_mask;
  logic             hit_dir;
  logic [GRP_W-1:0] mask_q;
  logic [GRP_W-1:0] dir_q;
  logic [GRP_W-1:0] q_q;

  assign addr_ext = 32'(ld_addr);
  assign hit_flop = ld_evt && (addr_ext == FLOP_A);
  assign hit_mask = ld_evt && (addr_ext == MASK_A);
  assign hit_dir  = ld_evt && (addr_ext == DIR_A);

  // Bits that the bus overwrites this cycle.
  assign ld_bits = hit_flop ? ~mask_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      dir_q  <= '0;
    end else begin
      if (hit_mask) mask_q <= ld_data;
      if (hit_dir)  dir_q  <= ld_data;
    end
  end

  for (genvar b = 0; b < GRP_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q[b] <= 1'b0;
      else        q_q[b] <= bit_next(ld_bits[b], ld_data[b], int_set[b],
                                     int_clr[b], int_ce[b], int_d[b], q_q[b]);
    end
    assign oe[b] = oe_bit(dir_q[b], term_cfg[b], oe_term[b], out_decl[b]);
  end

  assign q    = q_q;
  assign mask = mask_q;
  assign dir  = dir_q;

endmodule

// File: rtl/outreg_bank.sv
module outreg_bank
  import outreg_pkg::*;
#(
  parameter int GRP_W   = 8,
  parameter int NUM_GRP = 2,
  parameter int ADDR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     edge_mode,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [GRP_W-1:0]         bus_wdata,
  output logic [GRP_W-1:0]         bus_rdata,
  input  logic [GRP_W*NUM_GRP-1:0] int_d,
  input  logic [GRP_W*NUM_GRP-1:0] int_set,
  input  logic [GRP_W*NUM_GRP-1:0] int_clr,
  input  logic [GRP_W*NUM_GRP-1:0] int_ce,
  input  logic [GRP_W*NUM_GRP-1:0] oe_term,
  input  logic [GRP_W*NUM_GRP-1:0] term_cfg,
  input  logic [GRP_W*NUM_GRP-1:0] out_decl,
  output logic [GRP_W*NUM_GRP-1:0] q,
  output logic [GRP_W*NUM_GRP-1:0] oe
);

  localparam int NBITS = GRP_W * NUM_GRP;

  logic              ld_evt;
  logic [ADDR_W-1:0] ld_addr;
  logic [GRP_W-1:0]  ld_data;

  logic [NUM_GRP-1:0][GRP_W-1:0] q_grp;
  logic [NUM_GRP-1:0][GRP_W-1:0] mask_grp;
  logic [NUM_GRP-1:0][GRP_W-1:0] dir_grp;
  logic [NUM_GRP-1:0][GRP_W-1:0] oe_grp;
  logic [NUM_GRP-1:0][GRP_W-1:0] ldb_grp;

  // Named internal views for the checker.
  logic [NBITS-1:0] mask_all;
  logic [NBITS-1:0] dir_all;
  logic [NBITS-1:0] ld_bits;
  logic [NBITS-1:0] ld_rep;

  outreg_bus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(GRP_W)) bus_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_mode (edge_mode),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ld_evt    (ld_evt),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    outreg_group #(
      .GRP_W   (GRP_W),
      .ADDR_W  (ADDR_W),
      .NUM_GRP (NUM_GRP),
      .GRP_IDX (g)
    ) grp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_evt   (ld_evt),
      .ld_addr  (ld_addr),
      .ld_data  (ld_data),
      .int_d    (int_d[g*GRP_W +: GRP_W]),
      .int_set  (int_set[g*GRP_W +: GRP_W]),
      .int_clr  (int_clr[g*GRP_W +: GRP_W]),
      .int_ce   (int_ce[g*GRP_W +: GRP_W]),
      .oe_term  (oe_term[g*GRP_W +: GRP_W]),
      .term_cfg (term_cfg[g*GRP_W +: GRP_W]),
      .out_decl (out_decl[g*GRP_W +: GRP_W]),
      .q        (q_grp[g]),
      .mask     (mask_grp[g]),
      .dir      (dir_grp[g]),
      .oe       (oe_grp[g]),
      .ld_bits  (ldb_grp[g])
    );
  end

  assign q        = q_grp;
  assign oe       = oe_grp;
  assign mask_all = mask_grp;
  assign dir_all  = dir_grp;
  assign ld_bits  = ldb_grp;
  assign ld_rep   = {NUM_GRP{ld_data}};

  // Readback multiplexer.
  sel_e        rd_sel;
  int unsigned rd_grp;

  always_comb begin
    rd_sel    = addr_sel(32'(bus_addr), NUM_GRP);
    rd_grp    = addr_grp(32'(bus_addr), NUM_GRP);
    bus_rdata = '0;
    for (int unsigned g = 0; g < NUM_GRP; g++) begin
      if (rd_grp == g) begin
        case (rd_sel)
          SEL_FLOP: bus_rdata = q_grp[g];
          SEL_MASK: bus_rdata = mask_grp[g];
          SEL_DIR:  bus_rdata = dir_grp[g];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/outreg_bank_chk.sv
module outreg_bank_chk #(
  parameter int GRP_W   = 8,
  parameter int NUM_GRP = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     edge_mode,
  input logic                     bus_wr,
  input logic                     ld_evt,
  input logic [GRP_W*NUM_GRP-1:0] q,
  input logic [GRP_W*NUM_GRP-1:0] oe,
  input logic [GRP_W*NUM_GRP-1:0] mask_all,
  input logic [GRP_W*NUM_GRP-1:0] dir_all,
  input logic [GRP_W*NUM_GRP-1:0] ld_bits,
  input logic [GRP_W*NUM_GRP-1:0] ld_rep,
  input logic [GRP_W*NUM_GRP-1:0] int_set,
  input logic [GRP_W*NUM_GRP-1:0] int_clr,
  input logic [GRP_W*NUM_GRP-1:0] int_ce
);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == '0 && mask_all == '0 && dir_all == '0));

  // R2 and R5: every bus-loaded bit carries the load data one edge later.
  p_bus_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_evt |=> (((q ^ $past(ld_rep)) & $past(ld_bits)) == '0));

  p_edge_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && bus_wr) |-> !ld_evt);

  p_mask_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & $past(mask_all & ~int_set & ~int_clr & ~int_ce)) == '0));

  p_mask_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_bits & mask_all) == '0);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(int_set & ~ld_bits)) == $past(int_set & ~ld_bits)));

  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(int_clr & ~int_set & ~ld_bits)) == '0));

  p_oe_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe & dir_all) == dir_all);

endmodule

bind outreg_bank outreg_bank_chk #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .edge_mode (edge_mode),
  .bus_wr    (bus_wr),
  .ld_evt    (ld_evt),
  .q         (q),
  .oe        (oe),
  .mask_all  (mask_all),
  .dir_all   (dir_all),
  .ld_bits   (ld_bits),
  .ld_rep    (ld_rep),
  .int_set   (int_set),
  .int_clr   (int_clr),
  .int_ce    (int_ce)
);

// File: tb/outreg_bank_tb_top.sv
module outreg_bank_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        edge_mode;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] int_d, int_set, int_clr, int_ce;
  logic [15:0] oe_term, term_cfg, out_decl;
  logic [15:0] q, oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  outreg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_d(int_d), .int_set(int_set), .int_clr(int_clr), .int_ce(int_ce),
    .oe_term(oe_term), .term_cfg(term_cfg), .out_decl(out_decl),
    .q(q), .oe(oe)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference state built from the requirements.
  logic [15:0] m_q, m_mask, m_dir;
  logic        m_wrq;
  logic [2:0]  m_haddr;
  logic [7:0]  m_hdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_q[7:0];
      3'd1: return m_q[15:8];
      3'd2: return m_mask[7:0];
      3'd3: return m_mask[15:8];
      3'd4: return m_dir[7:0];
      3'd5: return m_dir[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] exp_oe();
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      r[i] = m_dir[i] || (term_cfg[i] ? oe_term[i] : out_decl[i]);
    return r;
  endfunction

  // One clock: check combinational outputs, predict, step, check flops.
  task automatic tick();
    logic        ev;
    logic [2:0]  ea;
    logic [7:0]  ed;
    logic [15:0] nq;
    #1;
    check("R7 readback", {24'h0, bus_rdata}, {24'h0, exp_rd(bus_addr)});
    check("R8 output enable", {16'h0, oe}, {16'h0, exp_oe()});
    if (edge_mode) begin
      ev = m_wrq && !bus_wr; ea = m_haddr; ed = m_hdata;
    end else begin
      ev = bus_wr; ea = bus_addr; ed = bus_wdata;
    end
    for (int i = 0; i < 16; i++) begin
      if (ev && (ea == 3'(i / 8)) && !m_mask[i]) nq[i] = ed[i % 8];
      else if (int_set[i]) nq[i] = 1'b1;
      else if (int_clr[i]) nq[i] = 1'b0;
      else if (int_ce[i])  nq[i] = int_d[i];
      else                 nq[i] = m_q[i];
    end
    @(posedge clk);
    if (ev && ea == 3'd2) m_mask[7:0]  = ed;
    if (ev && ea == 3'd3) m_mask[15:8] = ed;
    if (ev && ea == 3'd4) m_dir[7:0]   = ed;
    if (ev && ea == 3'd5) m_dir[15:8]  = ed;
    m_q   = nq;
    m_wrq = bus_wr;
    if (bus_wr) begin
      m_haddr = bus_addr;
      m_hdata = bus_wdata;
    end
    #1;
    check("R2 R3 R4 R5 R6 R9 flop state", {16'h0, q}, {16'h0, m_q});
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; edge_mode = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    int_d = '0; int_set = '0; int_clr = '0; int_ce = '0;
    oe_term = '0; term_cfg = '0; out_decl = '0;
    m_q = '0; m_mask = '0; m_dir = '0; m_wrq = 1'b0; m_haddr = '0; m_hdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: everything zero after reset
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a);
      #1 check("R1 reset readback", {24'h0, bus_rdata}, 32'h0);
    end
    check("R1 reset flops", {16'h0, q}, 32'h0);

    // R9 and R7: direction register write and readback
    bus_write(3'd4, 8'hA5);
    bus_addr = 3'd4;
    #1 check("R7 direction readback", {24'h0, bus_rdata}, 32'hA5);
    check("R8 oe from direction", {16'h0, oe}, 32'h00A5);
    out_decl = 16'hFFFF;
    #1 check("R8 declared output enabled", {16'h0, oe}, 32'hFFFF);
    term_cfg = 16'hFFFF; oe_term = 16'h0100;
    #1 check("R8 term replaces declaration", {16'h0, oe}, 32'h01A5);
    term_cfg = '0; oe_term = '0; out_decl = '0;
    bus_addr = 3'd6;
    #1 check("R7 unmapped address 6", {24'h0, bus_rdata}, 32'h0);
    bus_addr = 3'd7;
    #1 check("R7 unmapped address 7", {24'h0, bus_rdata}, 32'h0);

    // R4: mask 0x0F protects bits 3:0
    bus_write(3'd2, 8'h0F);
    bus_addr = 3'd2;
    #1 check("R4 mask readback", {24'h0, bus_rdata}, 32'h0F);
    bus_write(3'd0, 8'hFF);
    check("R4 masked write", {24'h0, q[7:0]}, 32'hF0);

    // R5: bus overrides preset on unmasked bits only
    int_set = 16'h00FF;
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h00;
    tick();
    check("R5 override with mask", {24'h0, q[7:0]}, 32'h0F);
    bus_wr = 1'b0; int_set = '0;
    tick();

    // R6: preset over clear, enable loads data
    int_set = 16'h0100; int_clr = 16'h0300; int_ce = 16'h0400; int_d = 16'h0400;
    tick();
    check("R6 set over clear", {24'h0, q[15:8]}, 32'h05);
    int_set = '0; int_clr = 16'h0100; int_ce = '0; int_d = '0;
    tick();
    check("R6 clear only", {24'h0, q[15:8]}, 32'h04);
    int_clr = '0;

    // R3: edge mode takes last data when the strobe falls
    edge_mode = 1'b1;
    bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h11;
    tick();
    check("R3 no load while strobe high", {24'h0, q[15:8]}, 32'h04);
    bus_wdata = 8'h3C;
    tick();
    check("R3 no load while strobe high", {24'h0, q[15:8]}, 32'h04);
    bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'hEE;
    tick();
    check("R3 load on strobe fall", {24'h0, q[15:8]}, 32'h3C);
    check("R3 other group untouched", {24'h0, q[7:0]}, 32'h0F);

    // R2: level mode follows data while strobe high
    edge_mode = 1'b0;
    bus_write(3'd2, 8'h00);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h5A;
    tick();
    check("R2 level load", {24'h0, q[7:0]}, 32'h5A);
    bus_wdata = 8'h66;
    tick();
    check("R2 level follows data", {24'h0, q[7:0]}, 32'h66);
    check("R2 other group untouched", {24'h0, q[15:8]}, 32'h3C);
    bus_wr = 1'b0;
    tick();

    // Random phases, level then edge
    void'($urandom(32'd4242));
    for (int ph = 0; ph < 2; ph++) begin
      edge_mode = ph[0];
      for (int c = 0; c < 500; c++) begin
        bus_wr    = ($urandom % 3) == 0;
        bus_addr  = 3'($urandom % 8);
        bus_wdata = 8'($urandom);
        int_d     = 16'($urandom);
        int_set   = 16'($urandom & $urandom & $urandom);
        int_clr   = 16'($urandom & $urandom);
        int_ce    = 16'($urandom);
        oe_term   = 16'($urandom);
        term_cfg  = 16'($urandom);
        out_decl  = 16'($urandom);
        tick();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule